// File: doc/BRIEF.md
# Auto-Negotiation Progress and Error Status Word

This block is a read-only status word that sits inside the management register file of an Ethernet PHY. It watches the link auto-negotiation machine and records the furthest point that machine has reached since the last management read. A read reports that furthest point and then restarts tracking from whatever state the machine is in at that moment. The same word carries two sticky error indications for 100 Mb/s operation: loss of the receive signal, and failure of the receive clock-recovery PLL to lock.

The management interface pulses `rd_stb_i` for one clock in the cycle it samples the word. `rd_data_o` is driven combinationally from stored state, so it is valid in that same cycle. The effects of the read (progress reload and flag clear) take hold at the end of that cycle. Reads have no handshake: every pulse is one access.

Top module: `neg_status_reg`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) sets the stored progress to Idle (complete 0, code 000) and clears both error flags, so a read after reset returns 16'h0000.
- R2: The read word holds the stored monitor code in bits 13:11, the stored complete indication in bit 4, the receive-lost flag in bit 10 and the PLL-lock flag in bit 9. All other bits read as 0.
- R3: Progress is ranked as the 4-bit value {complete, code}, with complete as the most significant bit. Codes run Idle 000, parallel detected 001, parallel detect failed 010, abilities matched 011, acknowledge mismatch 100, acknowledge matched 101, consistency mismatch 110, consistency matched 111. Finished is complete=1 with code 000. Between reads, the stored progress becomes the live value at any clock edge where the live value ranks higher.
- R4: A live value that ranks equal to or lower than the stored progress leaves the stored progress unchanged, so a later regression does not show in the next read.
- R5: At the clock edge that ends a read cycle, the stored progress is loaded with the live value of that cycle, whatever its rank. The following read reports at least that value.
- R6: In 100 Mb/s mode, a receive-lost event pulse sets bit 10. The bit stays set until a read or reset clears it.
- R7: In 100 Mb/s mode, a PLL-lock-failure event pulse sets bit 9. The bit stays set until a read or reset clears it.
- R8: A read clears both flags at the end of its cycle. If an event arrives in the same cycle as the read, the read returns the flag's prior value and the flag is set afterwards.
- R9: While `mode_100_i` is 0 (10 Mb/s mode), error events are ignored and both flags are held at 0, so they read 0. This holds after returning to 100 Mb/s mode until a new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| an_code_i | input | 3 | Live negotiation monitor code |
| an_done_i | input | 1 | Live negotiation-finished indication |
| rx_lost_evt_i | input | 1 | Receive-signal-lost event pulse |
| pll_err_evt_i | input | 1 | PLL-lock-failure event pulse |
| mode_100_i | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| rd_stb_i | input | 1 | One-cycle read access strobe |
| rd_data_o | output | 16 | Status word, valid during the read cycle |

## Verification
The bench sweeps every ordered pair of 4-bit progress ranks through a reload read, an excursion, a drop back to Idle and a checking read. A holder that compared only the 3-bit code would misrank the finished state below consistency matched. A holder that tracked the live state would report Idle instead of the peak.

Every combination of error events, read coincidence and speed mode is also applied. A flag that let the read win over a same-cycle event would lose that event. A flag that only masked its output in 10 Mb/s mode would reappear when the mode returned to 100 Mb/s.

Mid-sequence reads catch a read that forgets to reload the live state, because the next read would then show a stale peak from before the first read.

// File: rtl/neg_status_pkg.sv
package neg_status_pkg;
  localparam int CODE_W = 3;
  localparam int RANK_W = CODE_W + 1;

  typedef struct packed {
    logic              done;
    logic [CODE_W-1:0] code;
  } progress_t;

  function automatic logic [RANK_W-1:0] rank_of(progress_t p);
    return {p.done, p.code};
  endfunction
endpackage

// File: rtl/progress_tracker.sv
module progress_tracker
  import neg_status_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  progress_t live_i,
  input  logic      rd_stb_i,
  output progress_t held_o
);
  progress_t held_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)
      held_q <= '0;
    else if (rd_stb_i)
      held_q <= live_i;
    else if (rank_of(live_i) > rank_of(held_q))
      held_q <= live_i;
  end

  assign held_o = held_q;

  // Between reads the held rank never falls (R3, R4).
  assert_rank_monotone_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_stb_i |=> rank_of(held_q) >= $past(rank_of(held_q)));

  // A read reloads the live value of its cycle (R5).
  assert_reload_on_read_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_stb_i |=> held_q == $past(live_i));

  // A higher-ranked live value is captured at the next edge (R3).
  assert_capture_higher_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rd_stb_i && rank_of(live_i) > rank_of(held_q)) |=> held_q == $past(live_i));
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic enable_i,
  input  logic event_i,
  input  logic clear_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !enable_i)
      flag_q <= 1'b0;
    else if (event_i)
      flag_q <= 1'b1;
    else if (clear_i)
      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // An enabled event always leaves the flag set, even against a read (R6, R7, R8).
  assert_event_latches_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_i && event_i) |=> flag_q);

  // Without event or read the flag holds (R7).
  assert_flag_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_i && !event_i && !clear_i) |=> flag_q == $past(flag_q));

  // A read with no event clears the flag (R8).
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (clear_i && !event_i) |=> !flag_q);

  // 10 Mb/s mode keeps the flag at zero (R9).
  assert_slow_mode_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !enable_i |=> !flag_q);
endmodule

// File: rtl/neg_status_reg.sv
module neg_status_reg
  import neg_status_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DONE_BIT   = 4,
  parameter int CODE_LSB   = 11,
  parameter int RXLOST_BIT = 10,
  parameter int PLLERR_BIT = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] an_code_i,
  input  logic              an_done_i,
  input  logic              rx_lost_evt_i,
  input  logic              pll_err_evt_i,
  input  logic              mode_100_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int NFLAGS = 2;
  localparam int FLAG_POS [NFLAGS] = '{RXLOST_BIT, PLLERR_BIT};

  progress_t   live, held;
  logic [NFLAGS-1:0] evt, flag;

  assign live.done = an_done_i;
  assign live.code = an_code_i;
  assign evt       = {pll_err_evt_i, rx_lost_evt_i};

  progress_tracker u_progress (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .live_i  (live),
    .rd_stb_i(rd_stb_i),
    .held_o  (held)
  );

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    sticky_flag u_flag (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .enable_i(mode_100_i),
      .event_i (evt[g]),
      .clear_i (rd_stb_i),
      .flag_o  (flag[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[DONE_BIT]             = held.done;
    rd_data_o[CODE_LSB +: CODE_W]   = held.code;
    for (int i = 0; i < NFLAGS; i++)
      rd_data_o[FLAG_POS[i]] = flag[i];
  end

  // In 10 Mb/s mode, a read one cycle into the mode sees no flags (R9).
  assert_flags_dark_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !mode_100_i |=> (rd_data_o[RXLOST_BIT] == 1'b0 && rd_data_o[PLLERR_BIT] == 1'b0));

  // After reset the word reads zero (R1).
  assert_reset_zero_R1: assert property (@(posedge clk_i)
    rst_i |=> rd_data_o == '0);
endmodule

// File: tb/neg_status_reg_tb.sv
module neg_status_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  code = '0;
  logic        done = 1'b0;
  logic        rxe = 1'b0, ple = 1'b0;
  logic        mode = 1'b1;
  logic        rd = 1'b0;
  logic [15:0] dout;

  int checks = 0, fails = 0, cyc_cnt = 0;
  bit finished = 0;

  // Reference state
  int        m_rank = 0;
  bit        m_rx = 0, m_pll = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  neg_status_reg u_dut (
    .clk_i(clk), .rst_i(rst), .an_code_i(code), .an_done_i(done),
    .rx_lost_evt_i(rxe), .pll_err_evt_i(ple), .mode_100_i(mode),
    .rd_stb_i(rd), .rd_data_o(dout)
  );

  function automatic logic [15:0] expect_word();
    logic [15:0] w = 16'h0;
    w[13:11] = m_rank[2:0];
    w[4]     = m_rank[3];
    w[10]    = m_rx;
    w[9]     = m_pll;
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check a read mid-cycle, update the model at the edge.
  task automatic step(input int live_rank, input bit rx_ev, input bit pll_ev,
                      input bit m100, input bit do_rd, input string tag);
    @(negedge clk);
    code = live_rank[2:0]; done = live_rank[3];
    rxe = rx_ev; ple = pll_ev; mode = m100; rd = do_rd; rst = 1'b0;
    #1;
    if (do_rd) check(tag, dout, expect_word());
    @(posedge clk);
    if (do_rd) m_rank = live_rank;
    else if (live_rank > m_rank) m_rank = live_rank;
    if (!m100) begin m_rx = 0; m_pll = 0; end
    else begin
      m_rx  = rx_ev  ? 1'b1 : (do_rd ? 1'b0 : m_rx);
      m_pll = pll_ev ? 1'b1 : (do_rd ? 1'b0 : m_pll);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rd = 1'b0; rxe = 0; ple = 0;
    @(posedge clk); m_rank = 0; m_rx = 0; m_pll = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state reads all zero
    @(negedge clk); rst = 1'b0; #1;
    check("R1", dout, 16'h0000);

    // R3/R4/R5: every ordered pair of ranks
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        step(a, 0, 0, 1, 1, "R5");   // reload to a
        step(b, 0, 0, 1, 0, "R3");
        step(0, 0, 0, 1, 0, "R4");   // regress to Idle
        step(5, 0, 0, 1, 1, (b > a) ? "R3" : "R4"); // expect max(a,b); layout R2
      end

    // R6/R7/R8/R9: events against reads and modes
    for (int md = 0; md < 2; md++)
      for (int ev = 0; ev < 4; ev++)
        for (int same = 0; same < 2; same++) begin
          step(0, 0, 0, 1, 1, "R8");
          step(0, ev[0], ev[1], md[0], 0, md ? "R6" : "R9");
          step(0, same ? ev[0] : 1'b0, same ? ev[1] : 1'b0, md[0], 1, md ? "R7" : "R9");
          step(0, 0, 0, 1, 1, "R8");  // same-cycle event must survive the read
          step(0, 0, 0, 1, 1, "R8");
        end

    // R9: flags set, then mode drops to 10 and back
    step(0, 1, 1, 1, 0, "R6");
    step(0, 0, 0, 1, 1, "R7");
    step(0, 1, 1, 1, 0, "R6");
    step(0, 1, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 1, 1, "R9");

    // R1: mid-run reset clears progress and flags
    step(7, 1, 1, 1, 0, "R2");
    do_reset();
    @(negedge clk); rst = 1'b0; #1;
    check("R1", dout, 16'h0000);
    step(8, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, 1, "R2");  // finished state: bit 4 only

    finish_run();
  end
endmodule